// File: doc/BRIEF.md
# Register Bank with Atomic Bit-Set, Bit-Clear and Bit-Toggle Aliases

This block is a bank of control registers behind a simple single-cycle slave port. Each register occupies a 16-byte window that holds four word addresses. One holds a plain read/write location. The other three are write aliases that set, clear or invert only the bits written as 1. Software can then change one field atomically, with no read-modify-write sequence and no race with other writers.

A parameter bit per register says whether that register accepts the three aliases. A mask per register marks bits that a plain write cannot change. Those bits change only through the set or clear alias. A write to an alias of a register without alias support is dropped and flagged as a bus error. An address beyond the last register reads zero and is also flagged. Every register value drives a parallel output port for the logic it controls.

A transfer lasts one cycle while `busSel` is high. Read data and the error flag are valid during that cycle. A write takes effect on the clock edge that ends the transfer.

Top module: `alias_reg_bank`

## Requirements
- R1: A synchronous active-high reset loads each register k with its parameterised reset value, slice k of `RESET_VALS`.
- R2: The word address selects register index = byte address bits [ADDR_W-1:4] and an access kind from byte address bits [3:2]: 0 plain, 1 set, 2 clear, 3 toggle. A read at any of the four kinds returns the current register value with the error flag low.
- R3: A plain write replaces every bit not marked in the register's `SETCLR_ONLY` mask with the written data.
- R4: A set-alias write ORs the written data into the register, and bits written as 0 keep their value.
- R5: A clear-alias write clears every bit written as 1 and leaves the others unchanged.
- R6: A toggle-alias write inverts every bit written as 1 that is not marked in the `SETCLR_ONLY` mask. Two equal toggles restore the value.
- R7: Bits marked in `SETCLR_ONLY` keep their value on a plain write and change only through the set or clear alias.
- R8: For a register whose `ALIAS_EN` bit is 0, a set, clear or toggle write changes no register and raises `busErr` for that transfer. A plain write to such a register still works.
- R9: An access to an index at or above NUM_REGS raises `busErr`, reads zero and changes no register.
- R10: A written value is not visible before the ending clock edge. From the next cycle on it shows on `regOut` and in read data.
- R11: `busErr` is low when `busSel` is low and for every supported access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Transfer valid this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busWordAddr | input | ADDR_W-2 | Byte address bits [ADDR_W-1:2] |
| busWdata | input | DATA_W | Write data or bit mask |
| busRdata | output | DATA_W | Read data, valid while busSel is high |
| busErr | output | 1 | Error response for the current transfer |
| regOut | output | NUM_REGS*DATA_W | All register values, register k in slice k |

## Verification
The bench builds four 32-bit registers behind an 8-bit byte address. Register 2 has its aliases disabled, and register 1 has a set/clear-only nibble at bits 7:4. Every alias kind, the locked-bit exclusions and the rejected alias writes are therefore reachable on one instance. The 8-bit address leaves indices 4 to 15 free, so the out-of-range error and zero read-back are exercised as well. A software model computes every expected register value, including a double toggle and a plain write over the locked nibble.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  // Access kind decoded from byte address bits [3:2]
  typedef enum logic [1:0] {
    AK_PLAIN = 2'd0,
    AK_SET   = 2'd1,
    AK_CLR   = 2'd2,
    AK_TOG   = 2'd3
  } aliasKind_t;

  // Write strobes from control to datapath
  typedef struct packed {
    logic plain;
    logic set;
    logic clr;
    logic tog;
  } wrOp_t;
endpackage

// File: rtl/regbank_ctrl.sv
`timescale 1ns/1ps
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0] ALIAS_EN = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-3:0]   busWordAddr,
  output wrOp_t               wrOp,
  output logic [NUM_REGS-1:0] wrHit,
  output logic [NUM_REGS-1:0] rdSel,
  output logic                busErr
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]    idx;
  aliasKind_t          kind;
  logic [NUM_REGS-1:0] match;
  logic                inRange;
  logic                aliasOk;
  logic                isWrite;

  assign idx     = busWordAddr[ADDR_W-3:2];
  assign kind    = aliasKind_t'(busWordAddr[1:0]);
  assign isWrite = busSel & busWrite;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    assign match[k] = (idx == IDX_W'(k));
    assign wrHit[k] = isWrite & match[k] & ((kind == AK_PLAIN) | ALIAS_EN[k]);
    assign rdSel[k] = busSel & match[k];
  end

  assign inRange = |match;
  assign aliasOk = |(match & ALIAS_EN);

  always_comb begin
    wrOp.plain = isWrite & (kind == AK_PLAIN);
    wrOp.set   = isWrite & (kind == AK_SET);
    wrOp.clr   = isWrite & (kind == AK_CLR);
    wrOp.tog   = isWrite & (kind == AK_TOG);
  end

  assign busErr = busSel & (~inRange | (busWrite & (kind != AK_PLAIN) & ~aliasOk));

  // R2: at most one register is written per transfer
  p_hit_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(wrHit));
  // R11: no error response without a transfer
  p_err_idle_r11: assert property (@(posedge clk) disable iff (rst) !busSel |-> !busErr);
  // R8 / R9: a flagged transfer never reaches a register
  p_err_no_write_r8: assert property (@(posedge clk) disable iff (rst) busErr |-> (wrHit == '0));
endmodule

// File: rtl/regbank_dp.sv
`timescale 1ns/1ps
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS  = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] SETCLR_ONLY = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wrOp_t                      wrOp,
  input  logic [NUM_REGS-1:0]        wrHit,
  input  logic [NUM_REGS-1:0]        rdSel,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regOut,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = RESET_VALS[k*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] LOCK  = SETCLR_ONLY[k*DATA_W +: DATA_W];

    logic [DATA_W-1:0] nxt;

    always_comb begin
      nxt = regQ[k];
      if (wrOp.plain)    nxt = (regQ[k] & LOCK) | (wdata & ~LOCK);
      else if (wrOp.set) nxt = regQ[k] | wdata;
      else if (wrOp.clr) nxt = regQ[k] & ~wdata;
      else if (wrOp.tog) nxt = regQ[k] ^ (wdata & ~LOCK);
    end

    always_ff @(posedge clk) begin
      if (rst)           regQ[k] <= RST_V;
      else if (wrHit[k]) regQ[k] <= nxt;
    end

    assign regOut[k*DATA_W +: DATA_W] = regQ[k];

    // R1: reset loads the parameterised value
    p_reset_value_r1: assert property (@(posedge clk) rst |=> (regQ[k] == RST_V));
    // R7: plain writes leave set/clear-only bits alone
    p_locked_plain_r7: assert property (@(posedge clk) disable iff (rst)
      (wrHit[k] && wrOp.plain) |=> ((regQ[k] & LOCK) == ($past(regQ[k]) & LOCK)));
    // R4: every bit written as 1 through the set alias ends up 1
    p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
      (wrHit[k] && wrOp.set) |=> ((regQ[k] & $past(wdata)) == $past(wdata)));
    // R5: every bit written as 1 through the clear alias ends up 0
    p_clr_bits_r5: assert property (@(posedge clk) disable iff (rst)
      (wrHit[k] && wrOp.clr) |=> ((regQ[k] & $past(wdata)) == '0));
    // R8 / R9: a register not hit keeps its value
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !wrHit[k] |=> $stable(regQ[k]));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      rdata = rdata | (regQ[k] & {DATA_W{rdSel[k]}});
    end
  end
endmodule

// File: rtl/alias_reg_bank.sv
`timescale 1ns/1ps
module alias_reg_bank
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0]        ALIAS_EN    = '1,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS  = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] SETCLR_ONLY = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [ADDR_W-3:0]          busWordAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       busErr,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);
  wrOp_t               wrOp;
  logic [NUM_REGS-1:0] wrHit;
  logic [NUM_REGS-1:0] rdSel;

  regbank_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .ALIAS_EN(ALIAS_EN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .wrOp(wrOp), .wrHit(wrHit),
    .rdSel(rdSel), .busErr(busErr)
  );

  regbank_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
    .RESET_VALS(RESET_VALS), .SETCLR_ONLY(SETCLR_ONLY)
  ) u_dp (
    .clk(clk), .rst(rst), .wrOp(wrOp), .wrHit(wrHit), .rdSel(rdSel),
    .wdata(busWdata), .regOut(regOut), .rdata(busRdata)
  );
endmodule

// File: tb/alias_reg_bank_test.sv
`timescale 1ns/1ps
module alias_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS  = 4;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam logic [NREGS-1:0] AEN = 4'b1011;
  localparam logic [NREGS*DW-1:0] RSTV =
    {32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_00A0, 32'h1234_5678};
  localparam logic [NREGS*DW-1:0] LOCKV =
    {32'h0, 32'h0, 32'h0000_00F0, 32'h0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [AW-3:0] busWordAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic busErr;
  logic [NREGS*DW-1:0] regOut;

  int nChecks = 0;
  int nFails = 0;
  logic [DW-1:0] model [NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_reg_bank #(
    .NUM_REGS(NREGS), .DATA_W(DW), .ADDR_W(AW),
    .ALIAS_EN(AEN), .RESET_VALS(RSTV), .SETCLR_ONLY(LOCKV)
  ) uut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .regOut(regOut)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int k = 0; k < NREGS; k++)
      check(regOut[k*DW +: DW] === model[k], tag, regOut[k*DW +: DW], model[k]);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [DW-1:0] d, input string tag);
    int idx = int'(a[7:4]);
    int al = int'(a[3:2]);
    bit inR = idx < NREGS;
    bit expErr = !inR || (al != 0 && !AEN[idx]);
    logic [DW-1:0] lock;
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busWordAddr = a[7:2]; busWdata = d;
    #1;
    check(busErr === expErr, expErr ? (inR ? "R8 err" : "R9 err") : "R11 err",
          DW'(busErr), DW'(expErr));
    checkAll("R10 before edge");
    @(posedge clk);
    if (!expErr) begin
      lock = LOCKV[idx*DW +: DW];
      case (al)
        0: model[idx] = (model[idx] & lock) | (d & ~lock);
        1: model[idx] = model[idx] | d;
        2: model[idx] = model[idx] & ~d;
        default: model[idx] = model[idx] ^ (d & ~lock);
      endcase
    end
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    #1;
    checkAll(tag);
  endtask

  task automatic doRead(input logic [7:0] a, input string tag);
    int idx = int'(a[7:4]);
    bit inR = idx < NREGS;
    logic [DW-1:0] exp = inR ? model[idx] : '0;
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busWordAddr = a[7:2];
    #1;
    check(busRdata === exp, tag, busRdata, exp);
    check(busErr === !inR, inR ? "R11 read err" : "R9 read err", DW'(busErr), DW'(!inR));
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic testReset();
    for (int k = 0; k < NREGS; k++) model[k] = RSTV[k*DW +: DW];
    #1;
    checkAll("R1 reset");
    check(busErr === 1'b0, "R11 idle", DW'(busErr), 32'h0);
  endtask

  task automatic testPlainAndReads();
    doWrite(8'h00, 32'hCAFE_F00D, "R3 plain");
    doRead(8'h00, "R2 read plain");
    doRead(8'h04, "R2 read set alias");
    doRead(8'h08, "R2 read clr alias");
    doRead(8'h0C, "R2 read tog alias");
    doRead(8'h10, "R2 read reg1");
  endtask

  task automatic testAliasOps();
    doWrite(8'h04, 32'h0000_00F0, "R4 set");
    doWrite(8'h08, 32'hCA00_0000, "R5 clear");
    doWrite(8'h0C, 32'h0F0F_0F0F, "R6 toggle 1");
    doWrite(8'h0C, 32'h0F0F_0F0F, "R6 toggle 2");
    check(regOut[31:0] === 32'h00FE_F0FD, "R6 double toggle", regOut[31:0], 32'h00FE_F0FD);
  endtask

  task automatic testLockedBits();
    doWrite(8'h10, 32'hFFFF_FF0F, "R7 plain over locked");
    check(regOut[63:32] === 32'hFFFF_FFAF, "R7 locked value", regOut[63:32], 32'hFFFF_FFAF);
    doWrite(8'h14, 32'h0000_0050, "R7 set locked");
    doWrite(8'h18, 32'h0000_0080, "R7 clear locked");
    doWrite(8'h1C, 32'h0000_00FF, "R6 toggle skips locked");
    check(regOut[63:32] === 32'hFFFF_FF70, "R6 locked toggle", regOut[63:32], 32'hFFFF_FF70);
    doWrite(8'h10, 32'h0000_0000, "R7 plain zero");
    check(regOut[63:32] === 32'h0000_0070, "R7 locked kept", regOut[63:32], 32'h0000_0070);
  endtask

  task automatic testNoAlias();
    doWrite(8'h24, 32'hFFFF_FFFF, "R8 set ignored");
    doWrite(8'h28, 32'hFFFF_FFFF, "R8 clear ignored");
    doWrite(8'h2C, 32'hFFFF_FFFF, "R8 toggle ignored");
    check(regOut[95:64] === 32'hDEAD_BEEF, "R8 unchanged", regOut[95:64], 32'hDEAD_BEEF);
    doWrite(8'h20, 32'h5555_AAAA, "R8 plain allowed");
    doRead(8'h2C, "R2 read no-alias reg");
  endtask

  task automatic testOutOfRange();
    doWrite(8'h40, 32'hFFFF_FFFF, "R9 write ignored");
    doWrite(8'hF4, 32'hFFFF_FFFF, "R9 set ignored");
    doRead(8'h50, "R9 read zero");
    doRead(8'hFC, "R9 read zero top");
  endtask

  task automatic testTiming();
    doWrite(8'h30, 32'h0BAD_C0DE, "R10 write");
    doRead(8'h30, "R10 read next cycle");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testPlainAndReads();
    testAliasOps();
    testLockedBits();
    testNoAlias();
    testOutOfRange();
    testTiming();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule